// File: doc/BRIEF.md
# Tri-State Phase Frequency Detector

This block compares a reference clock with a feedback clock and produces the two pump commands that a charge pump would use. An asserted raise command switches on the sourcing current, and an asserted lower command switches on the sinking current. The model is synchronous and oversampled. A fast system clock samples both inputs through a synchronizer and detects their rising edges. Two flag registers hold pending edges. A common clear is issued only after both flags have been high together for a programmable number of system clocks.

A frequency error gives a sustained net raise or lower command, and not only a phase error does. A faster reference gives a raise-dominant output, which pushes the tuning voltage up. A faster feedback gives a lower-dominant output. At lock the two commands appear only as short, equal overlap pulses. A lock flag tracks how far apart the two edges fall in successive comparisons.

Top module: `pfd_top`

## Requirements
- R1: A rising edge on `ref_in` sets `up_o`. With `ref_in` changed between clock edges, `up_o` is low after the second following rising clock edge and high after the third.
- R2: A rising edge on `fb_in` sets `dn_o`, with the same three-clock latency as R1.
- R3: Once `up_o` and `dn_o` are both high, both stay high for exactly D system clocks and then clear together. D is `dly_cfg` for values 1 to 15, and a value of 0 is taken as 1.
- R4: Edges on both inputs in the same system clock cycle set both flags together. The result is only the D-cycle overlap pulse, with no cycle in which just one output is high.
- R5: When the reference edge leads the feedback edge by d system clocks, `up_o` alone is high for exactly d cycles. When the feedback leads by d, `dn_o` alone is high for exactly d cycles.
- R6: With a higher reference frequency than feedback frequency, the total number of cycles with only `up_o` high exceeds the total with only `dn_o` high. With the frequencies the other way round, the relation is reversed.
- R7: A comparison ends at each common clear. Its skew is the number of cycles in which exactly one output was high since the previous comparison. `lock_o` rises after 16 consecutive comparisons whose skew is at most `win_cfg`. After 15 such comparisons it is still low.
- R8: `lock_o` drops after the first comparison whose skew exceeds `win_cfg`.
- R9: A synchronous active-high `rst` clears both outputs, the overlap counter, the skew and lock counters and the synchronizers. `up_o`, `dn_o` and `lock_o` are low after the reset clock edge, even during a pending pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Feedback clock, asynchronous |
| dly_cfg | input | 4 | Overlap length D in system clocks (0 is taken as 1) |
| win_cfg | input | 8 | Largest skew in clocks counted as a matching comparison |
| up_o | output | 1 | Raise command, drives the sourcing current |
| dn_o | output | 1 | Lower command, drives the sinking current |
| lock_o | output | 1 | Lock indication |

## Verification
Two events can fall in the same system clock cycle: the setting of both flags, and the arrival of two synchronized edges. The bench provokes this by raising both inputs in the same half-period for every delay value from 1 to 15. It judges the result by counting, cycle by cycle, how many cycles each output was high alone and how many both were high. It expects zero single-output cycles and exactly D overlap cycles. The same counters are swept over lead distances in both directions, so the case with no skew can be told apart from the cases with a single cycle of skew.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int DLY_W       = 4;
    localparam int WIN_W       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int LOCK_RUN    = 16;
    localparam int RUN_W       = $clog2(LOCK_RUN + 1);

    typedef struct packed {
        logic up;
        logic dn;
    } pump_flags_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_UP   = 2'b01,
        PH_DN   = 2'b10,
        PH_BOTH = 2'b11
    } pump_phase_e;

    function automatic logic [DLY_W-1:0] eff_delay(input logic [DLY_W-1:0] d);
        return (d == '0) ? DLY_W'(1) : d;
    endfunction

    function automatic pump_phase_e phase_of(input pump_flags_t f);
        case ({f.dn, f.up})
            2'b01:   return PH_UP;
            2'b10:   return PH_DN;
            2'b11:   return PH_BOTH;
            default: return PH_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync
    import pfd_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // a rising edge is a single-cycle event
    a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_edge,
    input  logic              fb_edge,
    input  logic [DLY_W-1:0]  dly_cfg,
    output pump_flags_t       flags,
    output pump_phase_e       phase,
    output logic              cmp
);
    logic [DLY_W-1:0] ov_cnt;
    logic [DLY_W-1:0] ov_len;
    logic             both;

    assign ov_len = eff_delay(dly_cfg);
    assign both   = flags.up & flags.dn;
    assign cmp    = both && (ov_cnt == ov_len - DLY_W'(1));
    assign phase  = phase_of(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            ov_cnt <= '0;
        end else begin
            flags.up <= (flags.up & ~cmp) | ref_edge;
            flags.dn <= (flags.dn & ~cmp) | fb_edge;
            ov_cnt   <= (both && !cmp) ? ov_cnt + DLY_W'(1) : '0;
        end
    end

    a_r1_up_set: assert property (@(posedge clk) disable iff (rst)
        ref_edge |=> flags.up);
    a_r2_dn_set: assert property (@(posedge clk) disable iff (rst)
        fb_edge |=> flags.dn);
    a_r3_clear_after_delay: assert property (@(posedge clk) disable iff (rst)
        cmp |=> (!(flags.up && flags.dn) || $past(ref_edge && fb_edge)));
    a_r5_up_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.up) |-> $past(ref_edge));
    a_r5_dn_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.dn) |-> $past(fb_edge));
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pump_phase_e      phase,
    input  logic             cmp,
    input  logic [WIN_W-1:0] win_cfg,
    output logic             lock_o
);
    logic [WIN_W:0]   skew;
    logic [RUN_W-1:0] run;
    logic             single;
    logic             in_win;

    assign single = (phase == PH_UP) || (phase == PH_DN);
    assign in_win = skew <= {1'b0, win_cfg};
    assign lock_o = (run == RUN_W'(LOCK_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            skew <= '0;
            run  <= '0;
        end else begin
            if (cmp)
                skew <= '0;
            else if (single && !(&skew))
                skew <= skew + 1'b1;
            if (cmp) begin
                if (!in_win)
                    run <= '0;
                else if (run != RUN_W'(LOCK_RUN))
                    run <= run + 1'b1;
            end
        end
    end

    a_r8_lock_drop: assert property (@(posedge clk) disable iff (rst)
        (cmp && !in_win) |=> !lock_o);
    a_r7_lock_on_cmp: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(cmp));
endmodule

// File: rtl/pfd_top.sv
module pfd_top
    import pfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic [WIN_W-1:0] win_cfg,
    output logic             up_o,
    output logic             dn_o,
    output logic             lock_o
);
    logic [1:0]  raw;
    logic [1:0]  rise;
    pump_flags_t flags;
    pump_phase_e phase;
    logic        cmp;

    assign raw = {fb_in, ref_in};

    for (genvar i = 0; i < 2; i++) begin : g_in
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[i]),
            .rise (rise[i])
        );
    end

    pfd_core i_core (
        .clk      (clk),
        .rst      (rst),
        .ref_edge (rise[0]),
        .fb_edge  (rise[1]),
        .dly_cfg  (dly_cfg),
        .flags    (flags),
        .phase    (phase),
        .cmp      (cmp)
    );

    pfd_lock i_lock (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cmp     (cmp),
        .win_cfg (win_cfg),
        .lock_o  (lock_o)
    );

    assign up_o = flags.up;
    assign dn_o = flags.dn;

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!up_o && !dn_o && !lock_o));
endmodule

// File: tb/test_pfd_top.sv
module test_pfd_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [3:0] dly_cfg = 4'd1;
    logic [7:0] win_cfg = 8'd0;
    logic       up_o, dn_o, lock_o;

    int checks = 0;
    int errors = 0;
    int n_up = 0, n_dn = 0, n_both = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfd_top i_pfd_top (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .dly_cfg(dly_cfg), .win_cfg(win_cfg),
        .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o)
    );

    always @(negedge clk) begin
        if (up_o && !dn_o) n_up++;
        if (dn_o && !up_o) n_dn++;
        if (up_o && dn_o)  n_both++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        @(posedge clk);
        n_up = 0; n_dn = 0; n_both = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; ref_in = 0; fb_in = 0;
        @(negedge clk); rst = 1'b0;
    endtask

    // leader raised first, follower d cycles later; ref_leads selects leader
    task automatic pulse(input bit ref_leads, input int d);
        @(negedge clk);
        if (ref_leads) ref_in = 1'b1; else fb_in = 1'b1;
        repeat (d) @(negedge clk);
        ref_in = 1'b1; fb_in = 1'b1;
        repeat (d + 24) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset up", up_o, 0);
        check("R9 reset dn", dn_o, 0);
        check("R9 reset lock", lock_o, 0);

        // R1 latency
        dly_cfg = 4'd3;
        @(negedge clk); ref_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 up after 2 clocks", up_o, 0);
        @(negedge clk);
        check("R1 up after 3 clocks", up_o, 1);
        ref_in = 1'b0;
        repeat (3) @(negedge clk);
        // R2 latency, also closes the pending comparison
        fb_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 dn after 2 clocks", dn_o, 0);
        @(negedge clk);
        check("R2 dn after 3 clocks", dn_o, 1);
        fb_in = 1'b0;
        repeat (10) @(negedge clk);
        check("R3 cleared after overlap", up_o | dn_o, 0);

        // R3/R4 sweep of every delay, same-cycle edges
        for (int d = 0; d < 16; d++) begin
            dly_cfg = 4'(d);
            clr_counts();
            pulse(1'b1, 0);
            check($sformatf("R3 overlap dly=%0d", d), n_both, (d == 0) ? 1 : d);
            check($sformatf("R4 no single dly=%0d", d), n_up + n_dn, 0);
        end

        // R5 lead sweep both directions
        for (int dl = 1; dl < 16; dl += 4) begin
            dly_cfg = 4'(dl);
            for (int s = 1; s < 8; s++) begin
                clr_counts();
                pulse(1'b1, s);
                check($sformatf("R5 up lead %0d dly %0d", s, dl), n_up, s);
                check("R5 no dn alone", n_dn, 0);
                check("R3 overlap with lead", n_both, dl);
                clr_counts();
                pulse(1'b0, s);
                check($sformatf("R5 dn lead %0d dly %0d", s, dl), n_dn, s);
                check("R5 no up alone", n_up, 0);
            end
        end

        // R6 frequency error
        for (int dir = 0; dir < 2; dir++) begin
            do_reset();
            dly_cfg = 4'd2;
            clr_counts();
            fork
                for (int k = 0; k < 60; k++) begin
                    repeat ((dir == 0) ? 8 : 11) @(negedge clk); ref_in = 1'b1;
                    repeat ((dir == 0) ? 8 : 11) @(negedge clk); ref_in = 1'b0;
                end
                for (int k = 0; k < 60; k++) begin
                    repeat ((dir == 0) ? 11 : 8) @(negedge clk); fb_in = 1'b1;
                    repeat ((dir == 0) ? 11 : 8) @(negedge clk); fb_in = 1'b0;
                end
            join
            if (dir == 0) check("R6 fast ref gives up dominance", int'(n_up > n_dn), 1);
            else          check("R6 fast fb gives dn dominance", int'(n_dn > n_up), 1);
        end

        // R7/R8 lock window boundary
        do_reset();
        dly_cfg = 4'd2;
        win_cfg = 8'd3;
        for (int k = 0; k < 15; k++) pulse(k[0], 3);
        check("R7 no lock after 15", lock_o, 0);
        pulse(1'b1, 3);
        check("R7 lock after 16", lock_o, 1);
        pulse(1'b0, 0);
        check("R7 lock holds in window", lock_o, 1);
        pulse(1'b0, 4);
        check("R8 lock drops out of window", lock_o, 0);
        for (int k = 0; k < 16; k++) pulse(1'b1, 1);
        check("R7 relock", lock_o, 1);

        // R9 reset during pending pulse and with lock set
        @(negedge clk); ref_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 pending up before reset", up_o, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 up cleared", up_o, 0);
        check("R9 lock cleared", lock_o, 0);
        ref_in = 1'b0; rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 stays idle", up_o | dn_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule